// File: doc/BRIEF.md
# Interprocessor Message Queue Block

This block lets processors pass fixed-size messages to each other through a set of hardware queues. Software reaches each queue through a window of 32-bit registers on a simple register bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. A producer fills the message words of a queue's window and then writes the window's final word register, which pushes the whole message into that queue. A consumer reads the message words in ascending order. Its read of the final word register returns the last word and removes the message.

Each queue also has a read-only state register in a separate status region. The register reports how many messages are pending and whether a push was ever lost to a full queue. Each queue drives a level interrupt for as long as it holds at least one message.

The number of queues, the queue depth, the address width and the span of word registers inside a window are all parameters. The defaults give eight queues of four messages with sixteen 32-bit words each.

Top module: `msgq_top`

## Requirements
- R1: Address bit ADDR_W-1 selects the region: 0 is the data region and 1 is the status region. In the data region, addr[6:2] is the register index within a queue window and addr[7 +: QW] is the queue number. All other address bits, including the page bits from bit 16 upward, are ignored, so every page aliases the same queues. In the status region, addr[2 +: QW] is the queue number.
- R2: A write to register index 31 (LAST_REG) of a queue pushes a message of words 16..31 into that queue, whatever the value written, including zero. The written value becomes word 31 of the message.
- R3: Word registers 16..30 that were not written since the previous push of that queue are pushed as zero. A push clears the queue's staged words, and a push that is dropped also clears them.
- R4: A read of register index 16..30 returns that word of the oldest message and leaves the queue and its count unchanged.
- R5: A read of register index 31 returns word 31 of the oldest message and removes that message. Messages leave each queue in the order they were pushed, and the storage wraps correctly when the depth is not a power of two.
- R6: The status register of a queue returns the pending message count in bits 23:12, a sticky overflow flag in bit 31, and zero in all other bits.
- R7: A push to a queue that already holds DEPTH messages is dropped and sets that queue's overflow flag. The count and the stored messages stay unchanged.
- R8: A read of index 31 on an empty queue returns zero and leaves the count at zero. A read of indices 16..30 on an empty queue also returns zero.
- R9: irq[q] is high exactly while queue q holds one or more messages. It falls after the pop that empties the queue.
- R10: A synchronous active-high reset empties every queue, clears all counts, overflow flags and staged words, drives irq to zero and clears rdata.
- R11: rdata is updated one cycle after a cycle with re high and keeps its value until the next read.
- R12: Writes to data register indices 0..15 and writes to the status region have no effect. Reads of data indices 0..15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| we | input | 1 | Write strobe; takes precedence over re |
| re | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | NUM_Q | Per-queue level interrupt, high while the queue holds a message |

## Verification
The hardest case to reach from the ports is a lost push: a queue must hold DEPTH messages before one more push can arrive. The same holds for pointer wrap with a non-power-of-two depth, which only shows up after several fill and drain rounds. The bench uses a depth of three. It fills every queue to the brim and pushes one extra message into each. It then drains every queue word by word and repeats the whole round, so the read and write positions pass the wrap point. The dropped message carries its own sequence number, so any trace of it in the drained data shows up as a miscompare.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

   localparam int unsigned DATA_W     = 32;
   localparam int unsigned CNT_LSB    = 12;
   localparam int unsigned CNT_FIELD  = 12;
   localparam int unsigned OVF_BIT    = 31;

   typedef logic [DATA_W-1:0] word_t;

   // Builds the per-queue state word: count field plus sticky overflow flag
   function automatic word_t state_word(input logic ovf, input logic [CNT_FIELD-1:0] cnt);
      word_t w;
      w = '0;
      w[CNT_LSB +: CNT_FIELD] = cnt;
      w[OVF_BIT]              = ovf;
      return w;
   endfunction

endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
   import msgq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned QW        = 3,
   parameter int unsigned FIRST_REG = 16,
   parameter int unsigned LAST_REG  = 31,
   localparam int unsigned WORDS    = LAST_REG - FIRST_REG + 1,
   localparam int unsigned WIDX_W   = $clog2(WORDS)
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output logic [QW-1:0]     qsel,
   output logic [WIDX_W-1:0] widx,
   output logic              stage_wr,
   output logic              commit,
   output logic              peek,
   output logic              pop,
   output logic              status_rd
);

   logic       is_status;
   logic [4:0] ridx;
   logic [4:0] rel;
   logic       in_win;
   logic       is_last;
   logic       rd_ok;

   assign is_status = addr[ADDR_W-1];
   assign ridx      = addr[6:2];
   assign in_win    = (ridx >= 5'(FIRST_REG)) && (ridx <= 5'(LAST_REG));
   assign is_last   = (ridx == 5'(LAST_REG));
   assign rel       = ridx - 5'(FIRST_REG);
   assign widx      = rel[WIDX_W-1:0];
   assign rd_ok     = re && !we;

   assign qsel      = is_status ? addr[2 +: QW] : addr[7 +: QW];

   assign stage_wr  = we && !is_status && in_win && !is_last;
   assign commit    = we && !is_status && is_last;
   assign peek      = rd_ok && !is_status && in_win && !is_last;
   assign pop       = rd_ok && !is_status && is_last;
   assign status_rd = rd_ok && is_status;

   // Address bits that carry no meaning for this block (page bits, byte lanes)
   logic unused_addr;
   if (ADDR_W - 2 >= 7 + QW) begin : g_hi_unused
      assign unused_addr = ^{addr[1:0], addr[ADDR_W-2:7+QW]};
   end else begin : g_hi_none
      assign unused_addr = ^addr[1:0];
   end

endmodule

// File: rtl/msgq_stage.sv
module msgq_stage
   import msgq_pkg::*;
#(
   parameter int unsigned WORDS  = 16,
   parameter int unsigned WIDX_W = 4
)(
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic                         clear,
   input  logic [WIDX_W-1:0]            widx,
   input  word_t                        wdata,
   output logic [WORDS-1:0][DATA_W-1:0] msg
);

   localparam int unsigned HELD = WORDS - 1;

   logic [HELD-1:0][DATA_W-1:0] held;

   for (genvar i = 0; i < HELD; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst || clear) begin
            held[i] <= '0;
         end else if (wr_en && (widx == WIDX_W'(i))) begin
            held[i] <= wdata;
         end
      end
   end

   // The closing word travels with the commit strobe itself
   assign msg = {wdata, held};

endmodule

// File: rtl/msgq_fifo.sv
module msgq_fifo
   import msgq_pkg::*;
#(
   parameter int unsigned WORDS  = 16,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned CW     = 3,
   parameter int unsigned WIDX_W = 4,
   localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         commit,
   input  logic                         pop,
   input  logic [WORDS-1:0][DATA_W-1:0] msg_in,
   input  logic [WIDX_W-1:0]            rd_idx,
   output logic [CW-1:0]                cnt,
   output logic                         ovf,
   output word_t                        head_word
);

   logic [WORDS-1:0][DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic full, empty, do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = commit && !full;
   assign do_pop  = pop && !empty && !commit;

   // Pointer advance: free wrap for power-of-two depth, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nxt = wp + PW'(1);
      assign rp_nxt = rp + PW'(1);
   end else begin : g_wrap
      assign wp_nxt = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      assign rp_nxt = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wp] <= msg_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (do_push) begin
            wp <= wp_nxt;
         end
         if (do_pop) begin
            rp <= rp_nxt;
         end
         if (commit && full) begin
            ovf <= 1'b1;
         end
         if (do_push && !do_pop) begin
            cnt <= cnt + CW'(1);
         end else if (do_pop && !do_push) begin
            cnt <= cnt - CW'(1);
         end
      end
   end

   assign head_word = empty ? '0 : mem[rp][rd_idx];

endmodule

// File: rtl/msgq_top.sv
module msgq_top
   import msgq_pkg::*;
#(
   parameter int unsigned NUM_Q     = 8,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned FIRST_REG = 16,
   parameter int unsigned LAST_REG  = 31
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [NUM_Q-1:0]  irq
);

   localparam int unsigned QW     = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
   localparam int unsigned CW     = $clog2(DEPTH + 1);
   localparam int unsigned WORDS  = LAST_REG - FIRST_REG + 1;
   localparam int unsigned WIDX_W = $clog2(WORDS);

   // Elaboration-time parameter checks
   if (LAST_REG > 31 || FIRST_REG >= LAST_REG) begin : g_bad_window
      $error("word register span must fit a 32-register window");
   end
   if (CW > CNT_FIELD) begin : g_bad_depth
      $error("DEPTH does not fit the state count field");
   end
   if (7 + QW > 16 || ADDR_W < 17) begin : g_bad_addr
      $error("queue field must fit below the page bits");
   end
   if (DEPTH < 1 || NUM_Q < 1) begin : g_bad_size
      $error("NUM_Q and DEPTH must be at least one");
   end

   logic [QW-1:0]     qsel;
   logic [WIDX_W-1:0] widx;
   logic              stage_wr, commit, peek, pop, status_rd;
   logic              q_valid;

   msgq_decode #(
      .ADDR_W   (ADDR_W),
      .QW       (QW),
      .FIRST_REG(FIRST_REG),
      .LAST_REG (LAST_REG)
   ) u_dec (
      .addr     (addr),
      .we       (we),
      .re       (re),
      .qsel     (qsel),
      .widx     (widx),
      .stage_wr (stage_wr),
      .commit   (commit),
      .peek     (peek),
      .pop      (pop),
      .status_rd(status_rd)
   );

   assign q_valid = (32'(qsel) < NUM_Q);

   logic [NUM_Q-1:0][CW-1:0] q_cnt;
   logic [NUM_Q-1:0]         q_ovf;
   word_t                    q_head [NUM_Q];

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic                         hit;
      logic [WORDS-1:0][DATA_W-1:0] msg;

      assign hit = q_valid && (qsel == QW'(q));

      msgq_stage #(
         .WORDS (WORDS),
         .WIDX_W(WIDX_W)
      ) u_stage (
         .clk  (clk),
         .rst  (rst),
         .wr_en(stage_wr && hit),
         .clear(commit && hit),
         .widx (widx),
         .wdata(wdata),
         .msg  (msg)
      );

      msgq_fifo #(
         .WORDS (WORDS),
         .DEPTH (DEPTH),
         .CW    (CW),
         .WIDX_W(WIDX_W)
      ) u_fifo (
         .clk      (clk),
         .rst      (rst),
         .commit   (commit && hit),
         .pop      (pop && hit),
         .msg_in   (msg),
         .rd_idx   (widx),
         .cnt      (q_cnt[q]),
         .ovf      (q_ovf[q]),
         .head_word(q_head[q])
      );

      assign irq[q] = (q_cnt[q] != '0);
   end

   word_t rd_next;

   always_comb begin
      rd_next = '0;
      if (q_valid) begin
         if (status_rd) begin
            rd_next = state_word(q_ovf[qsel], CNT_FIELD'(q_cnt[qsel]));
         end else if (peek || pop) begin
            rd_next = q_head[qsel];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
      end else if (re && !we) begin
         rdata <= rd_next;
      end
   end

endmodule

// File: rtl/msgq_checker.sv
module msgq_checker #(
   parameter int unsigned NUM_Q  = 8,
   parameter int unsigned CW     = 3,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 20
)(
   input logic                     clk,
   input logic                     rst,
   input logic                     we,
   input logic                     re,
   input logic [ADDR_W-1:0]        addr,
   input logic [NUM_Q-1:0]         irq,
   input logic [NUM_Q-1:0][CW-1:0] q_cnt
);

   // R10: reset leaves every interrupt low
   a_r10_reset_quiet: assert property (@(posedge clk) rst |=> (irq == '0));

   // R9: an interrupt only rises after a write cycle
   a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
      (|(irq & ~$past(irq))) |-> $past(we));

   // R8/R9: an interrupt only falls after a read cycle or a reset
   a_r8_irq_fall: assert property (@(posedge clk) disable iff (rst)
      (|(~irq & $past(irq))) |-> ($past(re) || $past(rst)));

   // R1: one bus access touches at most one queue
   a_r1_single_queue: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) || ($countones(irq ^ $past(irq)) <= 1)));

   // R12: writes into the status region leave all counts alone
   a_r12_status_wr: assert property (@(posedge clk) disable iff (rst)
      (we && addr[ADDR_W-1]) |=> $stable(q_cnt));

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      // R7: count never exceeds depth
      a_r7_bound: assert property (@(posedge clk) disable iff (rst)
         q_cnt[q] <= CW'(DEPTH));
      // R2: count grows by at most one per cycle
      a_r2_step: assert property (@(posedge clk) disable iff (rst)
         $past(rst) || (32'(q_cnt[q]) <= 32'($past(q_cnt[q])) + 1));
   end

endmodule

bind msgq_top msgq_checker #(
   .NUM_Q (NUM_Q),
   .CW    (CW),
   .DEPTH (DEPTH),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .we   (we),
   .re   (re),
   .addr (addr),
   .irq  (irq),
   .q_cnt(q_cnt)
);

// File: tb/msgq_top_test.sv
module msgq_top_test;

   localparam int CLK_P = 10;
   localparam int NQ    = 4;
   localparam int DEPTH = 3;
   localparam int AW    = 20;
   localparam int WORDS = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic          re = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NQ-1:0] irq;

   int n_vec = 0;
   int n_bad = 0;
   logic ovf_m [NQ];

   always #(CLK_P/2) clk = ~clk;

   msgq_top #(
      .NUM_Q (NQ),
      .DEPTH (DEPTH),
      .ADDR_W(AW)
   ) uut (
      .clk  (clk),
      .rst  (rst),
      .addr (addr),
      .we   (we),
      .re   (re),
      .wdata(wdata),
      .rdata(rdata),
      .irq  (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] daddr(input int p, input int q, input int r);
      return AW'((p << 16) | (q << 7) | (r << 2));
   endfunction

   function automatic logic [AW-1:0] saddr(input int q);
      return AW'((1 << (AW-1)) | (q << 2));
   endfunction

   function automatic logic [31:0] pat(input int q, input int s, input int w);
      return 32'h8000_0000 | 32'(q << 20) | 32'(s << 8) | 32'(w);
   endfunction

   function automatic logic [31:0] st(input logic o, input int c);
      return {o, 7'b0, 12'(c), 12'b0};
   endfunction

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic send_full(input int p, input int q, input int s);
      for (int w = 0; w < WORDS; w++) wr(daddr(p, q, 16 + w), pat(q, s, w));
   endtask

   task automatic drain_check(input string req, input int q, input int s);
      logic [31:0] d;
      for (int w = 0; w < WORDS; w++) begin
         rd(daddr(0, q, 16 + w), d);
         chk(req, d, pat(q, s, w));
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int q = 0; q < NQ; q++) ovf_m[q] = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      do_reset();

      // R10 / R11: reset state
      chk("R10 irq", 32'(irq), 32'h0);
      chk("R11 rdata", rdata, 32'h0);
      for (int q = 0; q < NQ; q++) begin
         rd(saddr(q), d);
         chk("R10 status", d, st(1'b0, 0));
      end

      // R2 R5 R6 R7 R9 R4: two fill/overflow/drain rounds to cross the wrap
      for (int rnd = 0; rnd < 2; rnd++) begin
         for (int q = 0; q < NQ; q++) begin
            for (int m = 0; m < DEPTH; m++) begin
               send_full(0, q, rnd * 8 + m);
               rd(saddr(q), d);
               chk("R6 count", d, st(ovf_m[q], m + 1));
            end
            send_full(0, q, rnd * 8 + 7);
            ovf_m[q] = 1'b1;
            rd(saddr(q), d);
            chk("R7 overflow", d, st(1'b1, DEPTH));
         end
         chk("R9 all irq", 32'(irq), 32'((1 << NQ) - 1));
         for (int q = 0; q < NQ; q++) begin
            for (int w = 0; w < WORDS - 1; w++) begin
               rd(daddr(0, q, 16 + w), d);
               chk("R4 peek", d, pat(q, rnd * 8, w));
            end
            rd(saddr(q), d);
            chk("R4 count kept", d, st(1'b1, DEPTH));
            for (int m = 0; m < DEPTH; m++) begin
               drain_check("R5 order", q, rnd * 8 + m);
               rd(saddr(q), d);
               chk("R5 count", d, st(1'b1, DEPTH - 1 - m));
            end
            chk("R9 irq fall", 32'(irq[q]), 32'h0);
         end
      end

      // R3 / R2: partial message and zero-valued commit
      wr(daddr(0, 1, 19), 32'hDEAD_0003);
      wr(daddr(0, 1, 31), 32'h0);
      chk("R9 irq rise", 32'(irq), 32'h2);
      for (int w = 0; w < WORDS; w++) begin
         rd(daddr(0, 1, 16 + w), d);
         chk("R3 unwritten zero", d, (w == 3) ? 32'hDEAD_0003 : 32'h0);
      end
      wr(daddr(0, 1, 31), 32'h0);
      rd(saddr(1), d);
      chk("R2 zero commit", d, st(1'b1, 1));
      rd(daddr(0, 1, 19), d);
      chk("R3 stage cleared", d, 32'h0);
      rd(daddr(0, 1, 31), d);
      chk("R3 last zero", d, 32'h0);

      // R1: page and spare address bits alias the same queue
      send_full(5, 2, 40);
      rd(saddr(2), d);
      chk("R1 alias count", d, st(1'b1, 1));
      for (int w = 0; w < WORDS; w++) begin
         rd(daddr(0, 2, 16 + w) | AW'(1 << 12), d);
         chk("R1 alias data", d, pat(2, 40, w));
      end

      // R12: low window indices and status writes are inert
      wr(daddr(0, 3, 5), 32'h1234_5678);
      wr(daddr(0, 3, 31), 32'h0000_00AA);
      rd(daddr(0, 3, 5), d);
      chk("R12 low index read", d, 32'h0);
      rd(daddr(0, 3, 16), d);
      chk("R12 low index write", d, 32'h0);
      wr(saddr(3), 32'hFFFF_FFFF);
      rd(saddr(3), d);
      chk("R12 status write", d, st(1'b1, 1));

      // R11: rdata holds between reads
      rd(daddr(0, 3, 31), d);
      chk("R11 pop value", d, 32'h0000_00AA);
      repeat (3) @(negedge clk);
      chk("R11 hold", rdata, 32'h0000_00AA);

      // R8: pop and peek of an empty queue
      rd(daddr(0, 0, 31), d);
      chk("R8 empty pop", d, 32'h0);
      rd(daddr(0, 0, 20), d);
      chk("R8 empty peek", d, 32'h0);
      rd(saddr(0), d);
      chk("R8 count stays", d, st(1'b1, 0));
      chk("R8 irq low", 32'(irq), 32'h0);

      // R10: reset mid-run
      send_full(0, 1, 50);
      chk("R9 irq one", 32'(irq), 32'h2);
      do_reset();
      chk("R10 irq after", 32'(irq), 32'h0);
      chk("R10 rdata after", rdata, 32'h0);
      rd(saddr(1), d);
      chk("R10 status after", d, st(1'b0, 0));
      rd(daddr(0, 1, 31), d);
      chk("R10 queue empty", d, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule